// File: doc/BRIEF.md
# Upward-Growing Byte Stack Unit

This block holds an 8-bit stack pointer and a byte-wide internal RAM that together form a stack growing toward higher addresses. A caller issues push or pop commands, each with a direct operand address naming the byte to save or the byte to restore into. A push advances the pointer first and then copies the operand byte into the slot the pointer now names. A pop copies the slot the pointer names into the operand byte and only then steps the pointer back.

Every byte transfer goes through the single RAM port as a read followed by a write, so its length is fixed. Two further commands move a 16-bit value as two byte transfers back to back: the save takes the lower-addressed byte first, and the restore undoes it in reverse. A separate register port reads and loads the pointer. A host port reads and writes the RAM while the unit is idle; it is how operand bytes are placed and results fetched.

Top module: `byte_stack_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, sp_rdata is 07h and busy and done are low.
- R2: Command code 0 (byte push, operand address A) leaves SP one higher and writes the byte at A into RAM at the new SP.
- R3: Command code 1 (byte pop, operand address A) writes the byte at RAM[SP] into A and leaves SP one lower.
- R4: SP wraps modulo 256: a push at SP=FFh stores at 00h and leaves SP=00h, and a pop at SP=00h leaves SP=FFh. No flag is raised.
- R5: Command code 2 (word push, operand A) stores the byte at A in RAM[SP+1] and the byte at A+1 in RAM[SP+2], and adds 2 to SP.
- R6: Command code 3 (word pop, operand A) writes RAM[SP] into A+1 and RAM[SP-1] into A, and subtracts 2 from SP.
- R7: busy is high from the edge that accepts a command until its last transfer ends, and any command presented while busy is high is ignored.
- R8: A pointer write (sp_wr) in an idle cycle with no command loads SP at that edge, and a command in the next cycle uses the new value; a pointer write while busy is high or while a command is accepted is ignored.
- R9: The host port writes RAM at the edge when host_we is high and the unit is idle, and host_rdata shows the addressed byte one edge after host_addr is presented; host writes while busy is high are ignored.
- R10: done is high for exactly one cycle, two edges after the edge that accepts a byte command and four edges after one that accepts a word command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 2 | 0 byte push, 1 byte pop, 2 word push, 3 word pop |
| cmd_addr | input | AW | Direct operand address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_wr | input | 1 | Load the stack pointer |
| sp_wdata | input | AW | Value to load into the pointer |
| sp_rdata | output | AW | Current stack pointer |
| host_we | input | 1 | Host RAM write enable |
| host_addr | input | AW | Host RAM address |
| host_wdata | input | DW | Host RAM write data |
| host_rdata | output | DW | RAM read data, one edge after the address |

## Verification
The bench builds the unit with its default values, an 8-bit pointer and data byte, a 256-byte RAM and a reset pointer of 07h. With those sizes the pointer write port can place SP at FFh and 00h, so both wrap directions are reached in a handful of cycles. The 16-bit pair is also moved across the operand addresses A and A+1. Commands, pointer loads and host writes are driven into the middle of a word push to show that none of them disturbs it.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    OP_PUSH8  = 2'd0,
    OP_POP8   = 2'd1,
    OP_PUSH16 = 2'd2,
    OP_POP16  = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_st_e;
endpackage

// File: rtl/stack_ram.sv
module stack_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first single port: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/stack_sp.sv
module stack_sp #(
  parameter int            AW       = 8,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] sp
);
  always_ff @(posedge clk) begin
    if (rst)       sp <= SP_RESET;
    else if (inc)  sp <= sp + AW'(1);
    else if (dec)  sp <= sp - AW'(1);
    else if (load) sp <= load_val;
  end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [AW-1:0] sp,
  output logic          busy,
  output logic          done,
  output logic          accept,
  output logic [AW-1:0] seq_addr,
  output logic          seq_we,
  output logic          sp_inc,
  output logic          sp_dec,
  output logic [1:0]    cur_op,
  output logic [AW-1:0] cur_addr
);
  seq_st_e       st;
  logic          idx_q;
  logic          is_push;
  logic          is_word;
  logic          off;
  logic [AW-1:0] opnd;

  assign accept  = (st == ST_IDLE) && cmd_valid;
  assign is_push = ~cur_op[0];
  assign is_word = cur_op[1];
  // word push walks A then A+1; word pop walks A+1 then A
  assign off     = is_word & (is_push ? idx_q : ~idx_q);
  assign opnd    = cur_addr + AW'(off);

  always_comb begin
    seq_addr = sp;
    seq_we   = 1'b0;
    sp_inc   = 1'b0;
    sp_dec   = 1'b0;
    case (st)
      ST_RD: begin
        seq_addr = is_push ? opnd : sp;
        sp_inc   = is_push;
      end
      ST_WR: begin
        seq_addr = is_push ? sp : opnd;
        seq_we   = 1'b1;
        sp_dec   = ~is_push;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      idx_q    <= 1'b0;
      cur_op   <= 2'd0;
      cur_addr <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          cur_op   <= cmd_op;
          cur_addr <= cmd_addr;
          idx_q    <= 1'b0;
          busy     <= 1'b1;
          st       <= ST_RD;
        end
        ST_RD: st <= ST_WR;
        ST_WR: begin
          if (is_word && !idx_q) begin
            idx_q <= 1'b1;
            st    <= ST_RD;
          end else begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/byte_stack_unit.sv
module byte_stack_unit #(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  output logic          busy,
  output logic          done,
  input  logic          sp_wr,
  input  logic [AW-1:0] sp_wdata,
  output logic [AW-1:0] sp_rdata,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);
  logic          accept;
  logic [AW-1:0] sp;
  logic [AW-1:0] seq_addr;
  logic          seq_we;
  logic          sp_inc;
  logic          sp_dec;
  logic [1:0]    cur_op;
  logic [AW-1:0] cur_addr;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;
  logic          sp_load;

  stack_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .sp       (sp),
    .busy     (busy),
    .done     (done),
    .accept   (accept),
    .seq_addr (seq_addr),
    .seq_we   (seq_we),
    .sp_inc   (sp_inc),
    .sp_dec   (sp_dec),
    .cur_op   (cur_op),
    .cur_addr (cur_addr)
  );

  assign sp_load = sp_wr && !busy && !accept;

  stack_sp #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
    .clk     (clk),
    .rst     (rst),
    .inc     (sp_inc),
    .dec     (sp_dec),
    .load    (sp_load),
    .load_val(sp_wdata),
    .sp      (sp)
  );

  // the sequencer owns the port while busy; the byte read in the
  // read step loops straight back as write data in the write step
  assign ram_addr  = busy ? seq_addr  : host_addr;
  assign ram_we    = busy ? seq_we    : host_we;
  assign ram_wdata = busy ? ram_rdata : host_wdata;

  stack_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  assign sp_rdata   = sp;
  assign host_rdata = ram_rdata;
endmodule

// File: rtl/stack_chk.sv
module stack_chk #(
  parameter int            AW       = 8,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          busy,
  input logic          done,
  input logic          sp_wr,
  input logic [AW-1:0] sp_wdata,
  input logic [AW-1:0] sp_rdata,
  input logic [1:0]    cur_op,
  input logic [AW-1:0] cur_addr
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (sp_rdata == SP_RESET && !busy && !done));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_on_finish: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r7_cmd_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cur_op) && $stable(cur_addr)));

  a_r4_sp_single_step: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> ((sp_rdata - $past(sp_rdata)) == AW'(1) ||
                     ($past(sp_rdata) - sp_rdata) == AW'(1) ||
                     sp_rdata == $past(sp_rdata)));

  a_r8_sp_load: assert property (@(posedge clk) disable iff (rst)
    (sp_wr && !busy && !cmd_valid) |=> (sp_rdata == $past(sp_wdata)));

  a_r8_sp_write_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && sp_wr && sp_wdata != sp_rdata) |=>
      (sp_rdata != $past(sp_wdata) || $past(sp_wdata) == $past(sp_rdata) + AW'(1)
       || $past(sp_wdata) == $past(sp_rdata) - AW'(1)));
endmodule

bind byte_stack_unit stack_chk #(.AW(AW), .SP_RESET(SP_RESET)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .busy     (busy),
  .done     (done),
  .sp_wr    (sp_wr),
  .sp_wdata (sp_wdata),
  .sp_rdata (sp_rdata),
  .cur_op   (cur_op),
  .cur_addr (cur_addr)
);

// File: tb/sim_byte_stack_unit.sv
module sim_byte_stack_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_addr = 8'd0;
  logic       busy, done;
  logic       sp_wr = 1'b0;
  logic [7:0] sp_wdata = 8'd0;
  logic [7:0] sp_rdata;
  logic       host_we = 1'b0;
  logic [7:0] host_addr = 8'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  byte_stack_unit u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .busy(busy), .done(done), .sp_wr(sp_wr),
    .sp_wdata(sp_wdata), .sp_rdata(sp_rdata), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ram_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic ram_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic sp_load(input logic [7:0] v);
    @(negedge clk);
    sp_wr = 1'b1; sp_wdata = v;
    @(negedge clk);
    sp_wr = 1'b0;
  endtask

  // issue a command, count edges from acceptance to the done pulse
  task automatic run_cmd(input logic [1:0] op, input logic [7:0] a, input int exp_edges);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R7", "busy after accept", int'(busy), 1);
    n = 0;
    while (!done && n < 10) begin
      @(negedge clk);
      n++;
    end
    check("R10", "edges to done", n, exp_edges);
    @(negedge clk);
    check("R10", "done width", int'(done), 0);
  endtask

  task automatic t_reset;
    check("R1", "sp after reset", int'(sp_rdata), 8'h07);
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "done after reset", int'(done), 0);
  endtask

  task automatic t_push8;
    logic [7:0] d;
    ram_wr(8'h30, 8'hA5);
    ram_rd(8'h30, d);
    check("R9", "host readback", int'(d), 8'hA5);
    run_cmd(2'd0, 8'h30, 2);
    check("R2", "sp after push", int'(sp_rdata), 8'h08);
    ram_rd(8'h08, d);
    check("R2", "pushed byte", int'(d), 8'hA5);
  endtask

  task automatic t_pop8;
    logic [7:0] d;
    run_cmd(2'd1, 8'h40, 2);
    check("R3", "sp after pop", int'(sp_rdata), 8'h07);
    ram_rd(8'h40, d);
    check("R3", "popped byte", int'(d), 8'hA5);
  endtask

  task automatic t_word;
    logic [7:0] d;
    ram_wr(8'h50, 8'h34);
    ram_wr(8'h51, 8'h12);
    run_cmd(2'd2, 8'h50, 4);
    check("R5", "sp after word push", int'(sp_rdata), 8'h09);
    ram_rd(8'h08, d);
    check("R5", "low byte first", int'(d), 8'h34);
    ram_rd(8'h09, d);
    check("R5", "high byte on top", int'(d), 8'h12);
    run_cmd(2'd3, 8'h60, 4);
    check("R6", "sp after word pop", int'(sp_rdata), 8'h07);
    ram_rd(8'h61, d);
    check("R6", "high byte restored", int'(d), 8'h12);
    ram_rd(8'h60, d);
    check("R6", "low byte restored", int'(d), 8'h34);
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    sp_load(8'hFF);
    check("R8", "sp loaded", int'(sp_rdata), 8'hFF);
    run_cmd(2'd0, 8'h30, 2);
    check("R4", "sp wraps up", int'(sp_rdata), 8'h00);
    ram_rd(8'h00, d);
    check("R4", "byte at 00", int'(d), 8'hA5);
    ram_wr(8'h00, 8'h5C);
    run_cmd(2'd1, 8'h42, 2);
    check("R4", "sp wraps down", int'(sp_rdata), 8'hFF);
    ram_rd(8'h42, d);
    check("R4", "byte popped from 00", int'(d), 8'h5C);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] d;
    sp_load(8'h07);
    ram_wr(8'h70, 8'h11);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_addr = 8'h50;
    @(negedge clk);
    cmd_op = 2'd1; cmd_addr = 8'h70;
    sp_wr = 1'b1; sp_wdata = 8'h80;
    host_we = 1'b1; host_addr = 8'h70; host_wdata = 8'h99;
    repeat (3) @(negedge clk);
    check("R7", "busy mid word push", int'(busy), 1);
    cmd_valid = 1'b0; sp_wr = 1'b0; host_we = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check("R7", "no second command", int'(busy), 0);
    check("R8", "sp write ignored while busy", int'(sp_rdata), 8'h09);
    ram_rd(8'h70, d);
    check("R9", "host write ignored while busy", int'(d), 8'h11);
    ram_rd(8'h09, d);
    check("R7", "word push intact", int'(d), 8'h12);
  endtask

  task automatic t_load_then_cmd;
    logic [7:0] d;
    @(negedge clk);
    sp_wr = 1'b1; sp_wdata = 8'h20;
    @(negedge clk);
    sp_wr = 1'b0;
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 8'h51;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    check("R8", "sp after load then push", int'(sp_rdata), 8'h21);
    ram_rd(8'h21, d);
    check("R8", "push used loaded sp", int'(d), 8'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_push8();
    t_pop8();
    t_word();
    t_wrap();
    t_busy_ignore();
    t_load_then_cmd();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule